// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing for a parallel RGB display panel. Software-side logic supplies the active width and height, the sync pulse lengths and the front and back porch lengths for both directions. The block runs a pixel counter and a line counter over the resulting raster. From those counters it drives horizontal sync, vertical sync and data enable, each through its own polarity bit.

A request strobe with the coordinates of the next active pixel leads data enable by one clock, so a pixel source has one cycle to present data. A mode input picks the pixel-clock edge on which data enable is launched. A separate, optional setting picks the launch edge for the two sync outputs. When that setting is not enabled, sync follows the data edge.

All geometry and mode inputs are captured together only when the raster wraps to its origin. Values changed mid-frame therefore take effect from the next frame.

Top module: `disp_timing_gen`

## Requirements
- R1: A line lasts `hsync_len + hback + act_w + hfront` clocks. It runs in the order sync, back porch, active, front porch. The hsync pulse covers its first `hsync_len` clocks.
- R2: A frame lasts `vsync_len + vback + act_h + vfront` lines in the same order. The line counter advances when a line ends. The vsync pulse covers the first `vsync_len` lines, over every clock of those lines.
- R3: Data enable is active exactly for the `act_w` active clocks of each of the `act_h` active lines.
- R4: Each of `hsync_pol`, `vsync_pol` and `de_pol` sets the level of its output when active: 0 makes the active level low and 1 makes it high. The inactive level is the inverse.
- R5: `pix_req` is high exactly one clock before each clock in which data enable is active, when rising launch is selected. In that clock `pix_x` and `pix_y` give the coordinates of that pixel, counted from 0 at the top-left active pixel. Both are 0 while `pix_req` is low.
- R6: With `pix_rise` = 1, data enable changes just after the rising clock edge. With `pix_rise` = 0, it changes half a clock later, just after the falling edge.
- R7: With `sync_own` = 1, hsync and vsync launch on the rising edge when `sync_rise` = 1 and on the falling edge when it is 0. With `sync_own` = 0 they use the edge chosen by `pix_rise`.
- R8: Geometry, polarity and edge inputs are sampled only when the raster wraps from its last clock to its origin. A change in the middle of a frame leaves the rest of that frame unchanged.
- R9: A sync, front porch or back porch length of 0 removes that phase and shortens the period by the same amount.
- R10: While `rst_n` is low, each sync and enable output sits at its inactive level for the polarity presented at the inputs. `pix_req`, `pix_x` and `pix_y` are 0. The first rising edge after release places the raster at its origin. The outputs show that position after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_w | input | CW | Active pixels per line |
| act_h | input | CW | Active lines per frame |
| hsync_len | input | CW | Horizontal sync length in clocks |
| hfront | input | CW | Horizontal front porch in clocks |
| hback | input | CW | Horizontal back porch in clocks |
| vsync_len | input | CW | Vertical sync length in lines |
| vfront | input | CW | Vertical front porch in lines |
| vback | input | CW | Vertical back porch in lines |
| hsync_pol | input | 1 | Hsync active level (1 high, 0 low) |
| vsync_pol | input | 1 | Vsync active level (1 high, 0 low) |
| de_pol | input | 1 | Data enable active level (1 high, 0 low) |
| pix_rise | input | 1 | Data launch edge (1 rising, 0 falling) |
| sync_own | input | 1 | Sync uses its own edge setting when 1 |
| sync_rise | input | 1 | Sync launch edge when enabled (1 rising, 0 falling) |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Next-pixel request, one clock ahead of data enable |
| pix_x | output | CW | Column of the requested pixel |
| pix_y | output | CW | Row of the requested pixel |

## Verification
A reference geometry with every phase nonzero runs over whole frames. It separates the order of the phases and the place where each sync pulse ends. All eight polarity combinations and all eight edge-mode combinations are then swept. Outputs are sampled both before and after the falling edge, so a launch edge chosen wrongly shows up as a half-clock shift. Geometries with zero-length phases test the skipping of phases. A mid-frame rewrite of every input checks that the running frame finishes under the old values and that the next frame starts under the new ones.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;

    // Active-high timing flags, hs in the top bit
    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } flags_t;

    // Polarity and launch-edge selection
    typedef struct packed {
        logic hs_pol;
        logic vs_pol;
        logic de_pol;
        logic pix_rise;
        logic sync_own;
        logic sync_rise;
    } mode_t;

endpackage

// File: rtl/dtg_raster.sv
`timescale 1ns/1ps
module dtg_raster
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] act_w_i,
    input  logic [CW-1:0] act_h_i,
    input  logic [CW-1:0] hs_len_i,
    input  logic [CW-1:0] hfp_i,
    input  logic [CW-1:0] hbp_i,
    input  logic [CW-1:0] vs_len_i,
    input  logic [CW-1:0] vfp_i,
    input  logic [CW-1:0] vbp_i,
    input  mode_t         mode_i,
    output mode_t         mode_o,
    output flags_t        flags_o,
    output logic          req_o,
    output logic [CW-1:0] x_o,
    output logic [CW-1:0] y_o
);
    localparam int TW = CW + 2;

    typedef struct packed {
        logic [CW-1:0] w;
        logic [CW-1:0] h;
        logic [CW-1:0] hs;
        logic [CW-1:0] hfp;
        logic [CW-1:0] hbp;
        logic [CW-1:0] vs;
        logic [CW-1:0] vfp;
        logic [CW-1:0] vbp;
    } geom_t;

    typedef struct packed {
        logic          run;
        logic [TW-1:0] h;
        logic [TW-1:0] v;
        geom_t         g;
        mode_t         m;
    } state_t;

    state_t        s_d, s_q;
    geom_t         geom_in;
    logic [TW-1:0] htot, vtot, hstart, hend, vstart, vend;
    logic          line_end, frame_end;
    logic          hact, vact;

    always_comb begin
        geom_in.w   = act_w_i;
        geom_in.h   = act_h_i;
        geom_in.hs  = hs_len_i;
        geom_in.hfp = hfp_i;
        geom_in.hbp = hbp_i;
        geom_in.vs  = vs_len_i;
        geom_in.vfp = vfp_i;
        geom_in.vbp = vbp_i;
    end

    // Period and window bounds of the frame in flight
    always_comb begin
        htot   = TW'(s_q.g.w) + TW'(s_q.g.hs) + TW'(s_q.g.hfp) + TW'(s_q.g.hbp);
        vtot   = TW'(s_q.g.h) + TW'(s_q.g.vs) + TW'(s_q.g.vfp) + TW'(s_q.g.vbp);
        hstart = TW'(s_q.g.hs) + TW'(s_q.g.hbp);
        hend   = hstart + TW'(s_q.g.w);
        vstart = TW'(s_q.g.vs) + TW'(s_q.g.vbp);
        vend   = vstart + TW'(s_q.g.h);
        line_end  = (s_q.h + TW'(1)) >= htot;
        frame_end = s_q.run && line_end && ((s_q.v + TW'(1)) >= vtot);
    end

    // Next-state: origin and capture at wrap, else advance
    always_comb begin
        s_d = s_q;
        if (!s_q.run || frame_end) begin
            s_d.run = 1'b1;
            s_d.h   = '0;
            s_d.v   = '0;
            s_d.g   = geom_in;
            s_d.m   = mode_i;
        end else if (line_end) begin
            s_d.h = '0;
            s_d.v = s_q.v + TW'(1);
        end else begin
            s_d.h = s_q.h + TW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Phase decode, active-high
    always_comb begin
        hact       = (s_q.h >= hstart) && (s_q.h < hend);
        vact       = (s_q.v >= vstart) && (s_q.v < vend);
        flags_o.hs = s_q.run && (s_q.h < TW'(s_q.g.hs));
        flags_o.vs = s_q.run && (s_q.v < TW'(s_q.g.vs));
        flags_o.de = s_q.run && hact && vact;
        req_o      = flags_o.de;
        x_o        = flags_o.de ? CW'(s_q.h - hstart) : '0;
        y_o        = flags_o.de ? CW'(s_q.v - vstart) : '0;
        mode_o     = s_q.run ? s_q.m : mode_i;
    end

    // R1
    h_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && htot != '0) |-> (s_q.h < htot));

    // R2
    v_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && vtot != '0) |-> (s_q.v < vtot));

    // R2
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && line_end && !frame_end) |=> (s_q.h == '0 && s_q.v == $past(s_q.v) + TW'(1)));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !frame_end) |=> ($stable(s_q.g) && $stable(s_q.m)));

    // R3
    hs_de_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(flags_o.hs && flags_o.de));

endmodule

// File: rtl/dtg_launch.sv
`timescale 1ns/1ps
module dtg_launch
    import dtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t flags_i,
    input  mode_t  mode_i,
    output logic   de_pos_o,
    output logic   hsync_o,
    output logic   vsync_o,
    output logic   de_o
);
    localparam int NSIG = 3;

    flags_t          pos_d, pos_q, neg_d, neg_q;
    logic [NSIG-1:0] rise, pol, pos_v, neg_v, out_v;
    logic            sync_edge;

    always_comb begin
        pos_d     = flags_i;
        neg_d     = pos_q;
        sync_edge = mode_i.sync_own ? mode_i.sync_rise : mode_i.pix_rise;
        rise      = {sync_edge, sync_edge, mode_i.pix_rise};
        pol       = {mode_i.hs_pol, mode_i.vs_pol, mode_i.de_pol};
        pos_v     = pos_q;
        neg_v     = neg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    // Half-cycle delayed copy for falling-edge launch
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= '0;
        else        neg_q <= neg_d;
    end

    for (genvar i = 0; i < NSIG; i++) begin : g_out
        assign out_v[i] = (rise[i] ? pos_v[i] : neg_v[i]) ^ ~pol[i];
    end

    assign hsync_o  = out_v[2];
    assign vsync_o  = out_v[1];
    assign de_o     = out_v[0];
    assign de_pos_o = pos_q.de;

    // R6
    neg_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        neg_q == pos_q);

endmodule

// File: rtl/disp_timing_gen.sv
`timescale 1ns/1ps
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] act_w,
    input  logic [CW-1:0] act_h,
    input  logic [CW-1:0] hsync_len,
    input  logic [CW-1:0] hfront,
    input  logic [CW-1:0] hback,
    input  logic [CW-1:0] vsync_len,
    input  logic [CW-1:0] vfront,
    input  logic [CW-1:0] vback,
    input  logic          hsync_pol,
    input  logic          vsync_pol,
    input  logic          de_pol,
    input  logic          pix_rise,
    input  logic          sync_own,
    input  logic          sync_rise,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic          pix_req,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y
);
    mode_t  mode_in, mode_eff;
    flags_t flags;
    logic   de_pos;

    always_comb begin
        mode_in.hs_pol    = hsync_pol;
        mode_in.vs_pol    = vsync_pol;
        mode_in.de_pol    = de_pol;
        mode_in.pix_rise  = pix_rise;
        mode_in.sync_own  = sync_own;
        mode_in.sync_rise = sync_rise;
    end

    dtg_raster #(.CW(CW)) u_raster (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_w_i  (act_w),
        .act_h_i  (act_h),
        .hs_len_i (hsync_len),
        .hfp_i    (hfront),
        .hbp_i    (hback),
        .vs_len_i (vsync_len),
        .vfp_i    (vfront),
        .vbp_i    (vback),
        .mode_i   (mode_in),
        .mode_o   (mode_eff),
        .flags_o  (flags),
        .req_o    (pix_req),
        .x_o      (pix_x),
        .y_o      (pix_y)
    );

    dtg_launch u_launch (
        .clk      (clk),
        .rst_n    (rst_n),
        .flags_i  (flags),
        .mode_i   (mode_eff),
        .de_pos_o (de_pos),
        .hsync_o  (hsync),
        .vsync_o  (vsync),
        .de_o     (de)
    );

    // R5
    req_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_req |=> de_pos);

    // R10
    idle_coord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_req |-> (pix_x == '0 && pix_y == '0));

endmodule

// File: tb/disp_timing_gen_bench.sv
`timescale 1ns/1ps
module disp_timing_gen_bench;
    localparam int CW = 12;

    typedef struct {
        int w, h, hs, hfp, hbp, vs, vfp, vbp;
        bit hp, vp, dp, pr, so, sr;
    } bcfg_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    bcfg_t ic, mc;
    int nchk = 0, nfail = 0;
    bit done = 0;

    // bench model of raster position
    bit       mrun = 0;
    int       mh = 0, mv = 0;
    bit [2:0] pos_e = '0;

    logic hsync, vsync, de, pix_req;
    logic [CW-1:0] pix_x, pix_y;

    always #4 clk = ~clk;

    disp_timing_gen #(.CW(CW)) u_disp_timing_gen (
        .clk(clk), .rst_n(rst_n),
        .act_w(CW'(ic.w)), .act_h(CW'(ic.h)),
        .hsync_len(CW'(ic.hs)), .hfront(CW'(ic.hfp)), .hback(CW'(ic.hbp)),
        .vsync_len(CW'(ic.vs)), .vfront(CW'(ic.vfp)), .vback(CW'(ic.vbp)),
        .hsync_pol(ic.hp), .vsync_pol(ic.vp), .de_pol(ic.dp),
        .pix_rise(ic.pr), .sync_own(ic.so), .sync_rise(ic.sr),
        .hsync(hsync), .vsync(vsync), .de(de),
        .pix_req(pix_req), .pix_x(pix_x), .pix_y(pix_y)
    );

    function automatic bit [2:0] mflags(int h, int v, bcfg_t c);
        int hst = c.hs + c.hbp;
        int vst = c.vs + c.vbp;
        bit dv = (h >= hst) && (h < hst + c.w) && (v >= vst) && (v < vst + c.h);
        return {bit'(h < c.hs), bit'(v < c.vs), dv};
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(string tag);
        bit [2:0] oldp, nf;
        bcfg_t pe;
        bit srise, lend, fend;
        int htot, vtot;
        @(posedge clk);
        oldp = pos_e;
        if (!rst_n) begin
            mrun = 0; pos_e = '0; oldp = '0;
        end else begin
            pos_e = mrun ? mflags(mh, mv, mc) : 3'b000;
            htot = mc.w + mc.hs + mc.hfp + mc.hbp;
            vtot = mc.h + mc.vs + mc.vfp + mc.vbp;
            lend = (mh + 1) >= htot;
            fend = mrun && lend && ((mv + 1) >= vtot);
            if (!mrun || fend) begin
                mc = ic; mh = 0; mv = 0; mrun = 1;
            end else if (lend) begin
                mh = 0; mv = mv + 1;
            end else begin
                mh = mh + 1;
            end
        end
        pe = mrun ? mc : ic;
        srise = pe.so ? pe.sr : pe.pr;
        #2;
        // before the falling edge: rising-launch shows new value, falling-launch the old (R6 R7)
        check(tag, "hsync early", 32'(hsync), 32'((srise ? pos_e[2] : oldp[2]) ^ !pe.hp));
        check(tag, "vsync early", 32'(vsync), 32'((srise ? pos_e[1] : oldp[1]) ^ !pe.vp));
        check(tag, "de early",    32'(de),    32'((pe.pr ? pos_e[0] : oldp[0]) ^ !pe.dp));
        #4;
        check(tag, "hsync", 32'(hsync), 32'(pos_e[2] ^ !pe.hp));
        check(tag, "vsync", 32'(vsync), 32'(pos_e[1] ^ !pe.vp));
        check(tag, "de",    32'(de),    32'(pos_e[0] ^ !pe.dp));
        nf = mrun ? mflags(mh, mv, mc) : 3'b000;
        check(tag, "pix_req", 32'(pix_req), 32'(nf[0]));
        check(tag, "pix_x", 32'(pix_x), nf[0] ? 32'(mh - mc.hs - mc.hbp) : 32'd0);
        check(tag, "pix_y", 32'(pix_y), nf[0] ? 32'(mv - mc.vs - mc.vbp) : 32'd0);
    endtask

    task automatic restart(bcfg_t c);
        #1;
        ic = c;
        rst_n = 1'b0;
        step("R10");
        step("R10");
        #1;
        rst_n = 1'b1;
    endtask

    task automatic run_frames(string tag, bcfg_t c, int n);
        int len = (c.w + c.hs + c.hfp + c.hbp) * (c.h + c.vs + c.vfp + c.vbp);
        for (int i = 0; i < n * len + 2; i++) step(tag);
    endtask

    initial begin
        bcfg_t base, c, c2;
        base = '{w:4, h:3, hs:1, hfp:2, hbp:1, vs:1, vfp:1, vbp:1,
                 hp:1, vp:1, dp:1, pr:1, so:0, sr:0};
        ic = base;
        mc = base;
        step("R10");

        // R1 R2 R3 R5 reference geometry
        restart(base);
        run_frames("R1 R2 R3 R5", base, 2);

        // R4 all polarity combinations
        for (int p = 0; p < 8; p++) begin
            c = base;
            c.hp = p[2]; c.vp = p[1]; c.dp = p[0];
            restart(c);
            run_frames("R4", c, 1);
        end

        // R6 R7 all edge modes
        for (int m = 0; m < 8; m++) begin
            c = base;
            c.hp = 0; c.vp = 1; c.dp = 0;
            c.pr = m[0]; c.so = m[1]; c.sr = m[2];
            restart(c);
            run_frames("R6 R7", c, 1);
        end

        // R9 zero-length phases
        c = base;
        c.w = 3; c.h = 2; c.hs = 0; c.hfp = 0; c.hbp = 0; c.vs = 0; c.vfp = 0; c.vbp = 0;
        restart(c);
        run_frames("R9", c, 3);
        c = base;
        c.w = 2; c.h = 2; c.hs = 2; c.hfp = 0; c.hbp = 0; c.vs = 0; c.vfp = 1; c.vbp = 2;
        restart(c);
        run_frames("R9", c, 2);

        // R8 mid-frame rewrite of every input
        restart(base);
        for (int i = 0; i < 20; i++) step("R8");
        #1;
        c2 = '{w:5, h:2, hs:2, hfp:1, hbp:2, vs:2, vfp:2, vbp:1,
               hp:0, vp:0, dp:0, pr:0, so:1, sr:1};
        ic = c2;
        run_frames("R8", c2, 3);

        // R10 reset asserted mid-frame
        for (int i = 0; i < 13; i++) step("R10");
        restart(base);
        run_frames("R10", base, 1);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule